// File: doc/BRIEF.md
# Serial Audio Clock Ratio Checker

This block watches the clocks of a serial audio input and decides whether they can be trusted. It runs on a fast system clock and passes the bit clock, the word-select (frame) clock and the master clock through synchroniser chains. Each input has a rising-edge detector. The block counts bit-clock rising edges between consecutive word-select rising edges. A frame counts as legal only when it holds exactly 32, 48 or 64 bit periods. The three accepted counts are parameters.

The bit clock is declared good after two consecutive legal frames, and bad after a single illegal frame. It is also declared bad when no frame edge arrives within a timeout. A registered request drives the power output stage to high impedance whenever the bit clock is not good. The master clock is checked separately with a gap window. When the master clock goes missing, a clock-source select moves the reference from the master clock to the bit clock. It moves back once the master clock has run without a gap for one full window.

Top module: `audclk_ratio_mon`

## Requirements
- R1: While and right after synchronous reset, bck_valid is 0, out_hiz is 1, mclk_valid is 0 and clk_src_bck is 1.
- R2: A frame is the span between two consecutive rising edges of ws_in. It is legal when it contains exactly RATIO_0, RATIO_1 or RATIO_2 (defaults 32, 48, 64) rising edges of bck_in.
- R3: bck_valid becomes 1 only after two consecutive legal frames. The first ws_in rising edge after reset or after a timeout only starts counting and closes no frame.
- R4: One illegal frame (for example 31, 33, 40 or 65 bit periods) clears bck_valid a fixed few cycles after the closing ws_in edge. A new run of two legal frames is then needed.
- R5: out_hiz is always the complement of bck_valid: 1 requests a high-impedance output stage, 0 lets it switch.
- R6: The bit counter saturates and does not wrap. A frame of 192 bit periods is illegal, even though 192 modulo 128 equals 64.
- R7: If no ws_in rising edge arrives for WS_TIMEOUT system cycles, bck_valid goes to 0 and out_hiz goes to 1. An edge that comes sooner keeps the state.
- R8: If no mclk_in rising edge is seen for MCLK_WINDOW consecutive system cycles, mclk_valid goes to 0 and clk_src_bck goes to 1. Here 1 selects the bit clock and 0 selects the master clock.
- R9: mclk_valid returns to 1 and clk_src_bck to 0 only after MCLK_WINDOW consecutive cycles without a gap fault.
- R10: The master clock monitor and the bit clock monitor are independent. Losing mclk_in does not change bck_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than all audio clocks |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Asynchronous serial bit clock |
| ws_in | input | 1 | Asynchronous word-select (frame) clock |
| mclk_in | input | 1 | Asynchronous master clock |
| bck_valid | output | 1 | Bit-clock-to-frame ratio accepted |
| out_hiz | output | 1 | Request to put the output stage in high impedance |
| mclk_valid | output | 1 | Master clock present |
| clk_src_bck | output | 1 | Clock reference select: 1 = bit clock, 0 = master clock |

## Verification
The assertions assume that every high and low phase of the audio clocks lasts at least two system cycles, so that no edge is lost in the synchronisers. They also assume that ws_in never rises in the same system cycle as a bck_in rising edge. The stimulus drives bck_in with four-cycle phases and changes ws_in only while bck_in is low. All inputs change on the falling system clock edge. The master clock toggles every two cycles, so its gaps stay far below the window except when it is stopped on purpose.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  typedef enum int {
    SIG_BCK  = 0,
    SIG_WS   = 1,
    SIG_MCLK = 2
  } sig_idx_e;

  localparam int NUM_SIG = 3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/audclk_edge_sync.sv
module audclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq     <= '0;
      prev_q <= 1'b0;
      rise   <= 1'b0;
    end else begin
      sq     <= {sq[STAGES-2:0], d_in};
      prev_q <= sq[STAGES-1];
      rise   <= sq[STAGES-1] & ~prev_q;
    end
  end

  // R2: an edge yields one pulse, so it is counted once
  p_edge_single_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/audclk_frame_chk.sv
module audclk_frame_chk #(
  parameter int RATIO_0    = 32,
  parameter int RATIO_1    = 48,
  parameter int RATIO_2    = 64,
  parameter int WS_TIMEOUT = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_rise,
  input  logic ws_rise,
  output logic valid_q,
  output logic hiz_q
);
  localparam int RMAX  = audclk_pkg::max3(RATIO_0, RATIO_1, RATIO_2);
  localparam int CNT_W = $clog2(RMAX + 2);
  localparam int TMR_W = $clog2(WS_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] C0 = CNT_W'(RATIO_0);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(RATIO_1);
  localparam logic [CNT_W-1:0] C2 = CNT_W'(RATIO_2);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WS_TIMEOUT - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [TMR_W-1:0] ws_timer;
  logic             armed, streak;
  logic             legal, frame_end, timeout;
  logic             armed_d, streak_d, valid_d;

  always_comb begin
    legal     = (bit_cnt == C0) || (bit_cnt == C1) || (bit_cnt == C2);
    frame_end = ws_rise && armed;
    timeout   = (ws_timer == TMR_LAST) && !ws_rise;
    armed_d   = armed;
    streak_d  = streak;
    valid_d   = valid_q;
    if (timeout) begin
      armed_d  = 1'b0;
      streak_d = 1'b0;
      valid_d  = 1'b0;
    end else if (ws_rise) begin
      armed_d = 1'b1;
      if (armed) begin
        if (legal) begin
          streak_d = 1'b1;
          if (streak) valid_d = 1'b1;
        end else begin
          streak_d = 1'b0;
          valid_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      ws_timer <= '0;
      armed    <= 1'b0;
      streak   <= 1'b0;
      valid_q  <= 1'b0;
      hiz_q    <= 1'b1;
    end else begin
      if (ws_rise)
        bit_cnt <= '0;
      else if (bck_rise && bit_cnt != CNT_MAX)
        bit_cnt <= bit_cnt + 1'b1;
      if (ws_rise)
        ws_timer <= '0;
      else if (ws_timer != TMR_LAST)
        ws_timer <= ws_timer + 1'b1;
      armed   <= armed_d;
      streak  <= streak_d;
      valid_q <= valid_d;
      hiz_q   <= ~valid_d;
    end
  end

  // R3: validity is only granted by the second legal frame in a row
  p_valid_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(frame_end && legal && streak));
  // R4: an illegal frame revokes validity
  p_illegal_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !legal) |=> (!valid_q && hiz_q));
  // R6: the counter holds at its ceiling
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt == CNT_MAX && !ws_rise) |=> (bit_cnt == CNT_MAX));
  // R7: a missing frame edge revokes validity
  p_timeout_r7: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (!valid_q && hiz_q));
endmodule

// File: rtl/audclk_mclk_mon.sv
module audclk_mclk_mon #(
  parameter int MCLK_WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_rise,
  output logic valid_q,
  output logic src_bck_q
);
  localparam int WIN_W = $clog2(MCLK_WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(MCLK_WINDOW - 1);

  logic [WIN_W-1:0] gap_cnt, ok_cnt;
  logic             fault, valid_d;

  always_comb begin
    fault = !mclk_rise && (gap_cnt == WIN_LAST);
    if (fault)
      valid_d = 1'b0;
    else if (ok_cnt == WIN_LAST)
      valid_d = 1'b1;
    else
      valid_d = valid_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '0;
      ok_cnt    <= '0;
      valid_q   <= 1'b0;
      src_bck_q <= 1'b1;
    end else begin
      if (mclk_rise)
        gap_cnt <= '0;
      else if (!fault)
        gap_cnt <= gap_cnt + 1'b1;
      if (fault)
        ok_cnt <= '0;
      else if (ok_cnt != WIN_LAST)
        ok_cnt <= ok_cnt + 1'b1;
      valid_q   <= valid_d;
      src_bck_q <= ~valid_d;
    end
  end

  // R8: a full gap window drops the master clock
  p_mclk_fault_r8: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!valid_q && src_bck_q));
  // R9: recovery only after a full clean window
  p_mclk_recover_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(ok_cnt == WIN_LAST && mclk_rise | (ok_cnt == WIN_LAST)));
endmodule

// File: rtl/audclk_ratio_mon.sv
module audclk_ratio_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_0     = 32,
  parameter int RATIO_1     = 48,
  parameter int RATIO_2     = 64,
  parameter int WS_TIMEOUT  = 16384,
  parameter int MCLK_WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_in,
  input  logic ws_in,
  input  logic mclk_in,
  output logic bck_valid,
  output logic out_hiz,
  output logic mclk_valid,
  output logic clk_src_bck
);
  import audclk_pkg::*;

  logic [NUM_SIG-1:0] raw;
  logic [NUM_SIG-1:0] rise;

  assign raw[SIG_BCK]  = bck_in;
  assign raw[SIG_WS]   = ws_in;
  assign raw[SIG_MCLK] = mclk_in;

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sync
    audclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .d_in (raw[i]),
      .rise (rise[i])
    );
  end

  audclk_frame_chk #(
    .RATIO_0    (RATIO_0),
    .RATIO_1    (RATIO_1),
    .RATIO_2    (RATIO_2),
    .WS_TIMEOUT (WS_TIMEOUT)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .bck_rise (rise[SIG_BCK]),
    .ws_rise  (rise[SIG_WS]),
    .valid_q  (bck_valid),
    .hiz_q    (out_hiz)
  );

  audclk_mclk_mon #(.MCLK_WINDOW(MCLK_WINDOW)) u_mclk (
    .clk       (clk),
    .rst       (rst),
    .mclk_rise (rise[SIG_MCLK]),
    .valid_q   (mclk_valid),
    .src_bck_q (clk_src_bck)
  );
endmodule

// File: tb/audclk_ratio_mon_tb.sv
module audclk_ratio_mon_tb;
  localparam int WS_TO = 2000;
  localparam int MWIN  = 64;
  localparam int H     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bck_in = 1'b0, ws_in = 1'b0, mclk_in = 1'b0;
  logic bck_valid, out_hiz, mclk_valid, clk_src_bck;
  logic mclk_en = 1'b0;
  logic samp_valid, samp_hiz;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  audclk_ratio_mon #(.WS_TIMEOUT(WS_TO), .MCLK_WINDOW(MWIN)) u_dut (
    .clk(clk), .rst(rst), .bck_in(bck_in), .ws_in(ws_in), .mclk_in(mclk_in),
    .bck_valid(bck_valid), .out_hiz(out_hiz),
    .mclk_valid(mclk_valid), .clk_src_bck(clk_src_bck)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (mclk_en) begin
        c++;
        mclk_in = c[1];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // One frame of n bit periods, opened by a ws rise; outputs sampled 12 cycles in
  task automatic frame(input int n);
    for (int b = 0; b < n; b++) begin
      if (b == 0) ws_in = 1'b1;
      if (b == n / 2) ws_in = 1'b0;
      bck_in = 1'b0;
      repeat (H) @(negedge clk);
      if (b == 1) begin
        samp_valid = bck_valid;
        samp_hiz   = out_hiz;
      end
      bck_in = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1", "bck_valid in reset", bck_valid, 1'b0);
    chk("R1", "out_hiz in reset", out_hiz, 1'b1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bck_valid after reset", bck_valid, 1'b0);
    chk("R1", "out_hiz after reset", out_hiz, 1'b1);
    chk("R1", "mclk_valid after reset", mclk_valid, 1'b0);
    chk("R1", "clk_src_bck after reset", clk_src_bck, 1'b1);
  endtask

  task automatic t_mclk_start();
    mclk_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9", "mclk not yet valid mid window", mclk_valid, 1'b0);
    repeat (80) @(negedge clk);
    chk("R9", "mclk valid after clean window", mclk_valid, 1'b1);
    chk("R9", "source back to mclk", clk_src_bck, 1'b0);
  endtask

  // Starting unarmed: arm, two legal frames, then valid
  task automatic t_qualify(input string req);
    frame(64);
    chk(req, "invalid at arming edge", samp_valid, 1'b0);
    frame(64);
    chk(req, "invalid after one legal frame", samp_valid, 1'b0);
    chk("R5", "hiz while invalid", samp_hiz, 1'b1);
    frame(64);
    chk(req, "valid after two legal frames", samp_valid, 1'b1);
    chk("R5", "hiz released while valid", samp_hiz, 1'b0);
  endtask

  task automatic t_illegal(input string req, input int n);
    frame(n);
    chk(req, "valid before bad frame", samp_valid, 1'b1);
    frame(64);
    chk(req, $sformatf("invalid after %0d-bit frame", n), samp_valid, 1'b0);
    chk("R5", "hiz after bad frame", samp_hiz, 1'b1);
    frame(64);
    chk("R4", "one legal frame not enough", samp_valid, 1'b0);
    frame(64);
    chk("R4", "valid regained", samp_valid, 1'b1);
  endtask

  task automatic t_ratio(input int n);
    frame(n);
    frame(n);
    chk("R2", $sformatf("%0d-bit frame legal", n), samp_valid, 1'b1);
    frame(64);
    chk("R2", $sformatf("second %0d-bit frame legal", n), samp_valid, 1'b1);
    chk("R5", "hiz released", samp_hiz, 1'b0);
  endtask

  task automatic t_timeout();
    bck_in = 1'b0;
    ws_in  = 1'b0;
    repeat (1000) @(negedge clk);
    chk("R7", "still valid before timeout", bck_valid, 1'b1);
    repeat (1100) @(negedge clk);
    chk("R7", "invalid after timeout", bck_valid, 1'b0);
    chk("R7", "hiz after timeout", out_hiz, 1'b1);
    t_qualify("R3");
  endtask

  task automatic t_mclk_loss();
    fork
      begin frame(64); frame(64); end
      begin repeat (100) @(negedge clk); mclk_en = 1'b0; end
    join
    chk("R8", "mclk invalid after gap", mclk_valid, 1'b0);
    chk("R8", "source moved to bck", clk_src_bck, 1'b1);
    chk("R10", "bck frames still valid", samp_valid, 1'b1);
    chk("R10", "bck_valid unaffected", bck_valid, 1'b1);
    mclk_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9", "no early mclk recovery", mclk_valid, 1'b0);
    repeat (70) @(negedge clk);
    chk("R9", "mclk recovered", mclk_valid, 1'b1);
    chk("R9", "source back to mclk", clk_src_bck, 1'b0);
  endtask

  initial begin
    t_reset();
    t_mclk_start();
    t_qualify("R3");
    t_ratio(48);
    t_ratio(32);
    t_illegal("R4", 40);
    t_illegal("R4", 31);
    t_illegal("R4", 33);
    t_illegal("R4", 65);
    t_illegal("R6", 192);
    t_timeout();
    t_mclk_loss();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule